// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block is a hardware master that loads a configuration bitstream into a target FPGA over a slave-serial link. A one-cycle start pulse launches a load of a known number of bytes, which arrive on a valid/ready byte stream. The block first runs the reset handshake with the target. It raises the program request and waits for the target's INIT indication to become active. It then releases the request and waits for INIT to clear. After that it shifts every byte out on a data line under a generated configuration clock.

Before each byte the block checks whether the target reports a checksum failure, which shows as INIT active while DONE is low. After the last byte it holds the data line high and keeps pulsing the clock until the target raises DONE. Every wait is bounded by a cycle-count timeout. The outcome is reported as a one-cycle success pulse or a one-cycle error pulse with a code that tells the cause. After that, every output returns to its idle level.

Top module: `serial_cfg_loader`

## Requirements
- R1: A start pulse while idle raises busy and the program request on the next cycle. A start pulse while busy has no effect, so the program request is raised only once per load.
- R2: The program request stays high until initIn is seen high, and falls only after that. If initIn does not rise within the timeout, the load fails with errCode 1.
- R3: After the program request falls, no configuration clock edge occurs and no byte is accepted until initIn is seen low. If initIn does not clear within the timeout, the load fails with errCode 1.
- R4: Each byte is sent most significant bit first as eight clock periods. In each period cfgClk is low for HALF_PERIOD cycles and then high for HALF_PERIOD cycles. cfgDin changes only while cfgClk is low and stays stable while it is high, so the target samples each bit on the rising edge.
- R5: Before each byte, if initIn is 1 and doneIn is 0, the load stops with errCode 2 and no further byte is accepted.
- R6: Once all bytes are sent, including a load of zero bytes, cfgDin is held at 1 and clock periods continue until doneIn is seen high. The block then pulses doneOk and issues no further rising edges.
- R7: If doneIn does not rise within the timeout after the last byte, the load fails with errCode 3. cfgDin stays 1 on every trailing clock.
- R8: A load ends with exactly one single-cycle pulse of doneOk or of errValid. errCode is 0 whenever errValid is low. One cycle after the pulse, busy, progReq, cfgClk and inReady are 0 and cfgDin is 1, which are also the levels after reset.
- R9: The timeout counter restarts at the start of each wait phase and ends that phase after TIMEOUT_CYC cycles in it.
- R10: inReady is high only between bits while the clock is low. Exactly totalBytes bytes are accepted on a successful load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle load request |
| totalBytes | input | LEN_W | Number of bytes in the load, sampled at start |
| inData | input | 8 | Byte from the upstream stream |
| inValid | input | 1 | Upstream byte is valid |
| inReady | output | 1 | Byte accepted on this cycle when inValid is high |
| progReq | output | 1 | Program request to the target (active high) |
| initIn | input | 1 | Target INIT indication, 1 = active |
| doneIn | input | 1 | Target DONE indication, 1 = configured |
| cfgClk | output | 1 | Configuration clock to the target |
| cfgDin | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress, including the result cycle |
| doneOk | output | 1 | One-cycle success pulse |
| errValid | output | 1 | One-cycle failure pulse |
| errCode | output | 2 | 1 INIT timeout, 2 checksum fault, 3 DONE timeout, 0 otherwise |

## Verification
The bench plays the target, sampling cfgDin at each rising cfgClk edge. One scenario raises INIT after two bytes to force a checksum abort. A design that checked only once, or after the byte, would accept a third byte or report the wrong code. Zero-length loads catch a block that shifts a phantom byte before the trailing clocks. Trailing-edge counts catch one that keeps clocking after DONE. Separate timeouts in each wait phase, with a cycle window on the first one, catch a timer that is never restarted or a wrong code for the phase. A start pulse injected mid-load catches a controller that restarts the handshake.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [1:0] {
    ERR_NONE         = 2'd0,
    ERR_INIT_TIMEOUT = 2'd1,
    ERR_CRC          = 2'd2,
    ERR_DONE_TIMEOUT = 2'd3
  } errCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic clrCount;
    logic loadByte;
    logic clkRun;
    logic tailMode;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic periodEnd;
    logic lastBit;
    logic allSent;
    logic timeUp;
  } dpStat_t;

endpackage

// File: rtl/cfgld_datapath.sv
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int TIMEOUT_CYC = 1000000,
  parameter int LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [7:0]       inData,
  input  logic [LEN_W-1:0] totalBytes,
  output dpStat_t          stat,
  output logic             cfgClk,
  output logic             cfgDin
);
  // at least two cycles per half so data settles a cycle before the rise
  localparam int EFF_HALF = (HALF_PERIOD < 2) ? 2 : HALF_PERIOD;
  localparam int DIV_W    = $clog2(EFF_HALF + 1);
  localparam int EFF_TO   = (TIMEOUT_CYC < 2) ? 2 : TIMEOUT_CYC;
  localparam int TMR_W    = $clog2(EFF_TO + 1);

  logic [DIV_W-1:0] divCnt;
  logic             clkLevel;
  logic             halfTick;
  logic [7:0]       shiftReg;
  logic [2:0]       bitCnt;
  logic [LEN_W-1:0] byteCnt;
  logic [LEN_W-1:0] totalReg;
  logic [TMR_W-1:0] timerCnt;
  logic             dinReg;

  assign halfTick = ctl.clkRun && (divCnt == DIV_W'(EFF_HALF - 1));

  // clock divider: low half then high half
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.clkRun) begin
      divCnt   <= '0;
      clkLevel <= 1'b0;
    end else if (halfTick) begin
      divCnt   <= '0;
      clkLevel <= ~clkLevel;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign stat.periodEnd = halfTick && clkLevel;
  assign stat.lastBit   = stat.periodEnd && (bitCnt == 3'd7) && !ctl.tailMode;

  // shift register, MSB first, refilled with ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= 8'hFF;
      bitCnt   <= '0;
    end else if (ctl.loadByte) begin
      shiftReg <= inData;
      bitCnt   <= '0;
    end else if (stat.periodEnd && !ctl.tailMode) begin
      shiftReg <= {shiftReg[6:0], 1'b1};
      bitCnt   <= bitCnt + 3'd1;
    end
  end

  // byte accounting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      totalReg <= '0;
    end else if (ctl.clrCount) begin
      byteCnt  <= '0;
      totalReg <= totalBytes;
    end else if (ctl.loadByte) begin
      byteCnt <= byteCnt + LEN_W'(1);
    end
  end

  assign stat.allSent = (byteCnt == totalReg);

  // wait-phase timeout
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrTimer) begin
      timerCnt <= '0;
    end else if (!stat.timeUp) begin
      timerCnt <= timerCnt + TMR_W'(1);
    end
  end

  assign stat.timeUp = (timerCnt == TMR_W'(EFF_TO - 1));

  // data registered one cycle behind the shift so it moves while clock is low
  always_ff @(posedge clk) begin
    if (!rstN) dinReg <= 1'b1;
    else       dinReg <= ctl.tailMode ? 1'b1 : shiftReg[7];
  end

  assign cfgClk = clkLevel;
  assign cfgDin = dinReg;

  assert_din_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> $stable(cfgDin));

  assert_load_clk_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadByte |-> !cfgClk);

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       initIn,
  input  logic       doneIn,
  input  logic       inValid,
  input  dpStat_t    stat,
  output dpCtrl_t    ctl,
  output logic       progReq,
  output logic       busy,
  output logic       inReady,
  output logic       doneOk,
  output logic       errValid,
  output logic [1:0] errCode
);
  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_INIT_CLR, S_FETCH, S_SHIFT, S_TAIL, S_REPORT
  } state_e;

  state_e   state, nextState;
  logic     resOk, nextResOk;
  errCode_e errReg, nextErr;
  logic     crcFault;

  assign crcFault = initIn && !doneIn;

  always_comb begin
    nextState    = state;
    nextResOk    = resOk;
    nextErr      = errReg;
    ctl          = '0;
    ctl.clrTimer = 1'b1;
    case (state)
      S_IDLE: if (start) begin
        nextState    = S_PROG;
        ctl.clrCount = 1'b1;
        nextErr      = ERR_NONE;
        nextResOk    = 1'b0;
      end
      S_PROG: begin
        ctl.clrTimer = 1'b0;
        if (initIn) begin
          nextState    = S_INIT_CLR;
          ctl.clrTimer = 1'b1;
        end else if (stat.timeUp) begin
          nextState = S_REPORT;
          nextErr   = ERR_INIT_TIMEOUT;
        end
      end
      S_INIT_CLR: begin
        ctl.clrTimer = 1'b0;
        if (!initIn) begin
          nextState = S_FETCH;
        end else if (stat.timeUp) begin
          nextState = S_REPORT;
          nextErr   = ERR_INIT_TIMEOUT;
        end
      end
      S_FETCH: begin
        if (stat.allSent) begin
          nextState = S_TAIL;
        end else if (crcFault) begin
          nextState = S_REPORT;
          nextErr   = ERR_CRC;
        end else if (inValid) begin
          ctl.loadByte = 1'b1;
          nextState    = S_SHIFT;
        end
      end
      S_SHIFT: begin
        ctl.clkRun = 1'b1;
        if (stat.lastBit) nextState = S_FETCH;
      end
      S_TAIL: begin
        ctl.clrTimer = 1'b0;
        ctl.tailMode = 1'b1;
        if (doneIn) begin
          nextState = S_REPORT;
          nextResOk = 1'b1;
        end else if (stat.timeUp) begin
          nextState = S_REPORT;
          nextErr   = ERR_DONE_TIMEOUT;
        end else begin
          ctl.clkRun = 1'b1;
        end
      end
      S_REPORT: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      resOk  <= 1'b0;
      errReg <= ERR_NONE;
    end else begin
      state  <= nextState;
      resOk  <= nextResOk;
      errReg <= nextErr;
    end
  end

  assign progReq  = (state == S_PROG);
  assign busy     = (state != S_IDLE);
  assign inReady  = (state == S_FETCH) && !stat.allSent && !crcFault;
  assign doneOk   = (state == S_REPORT) && resOk;
  assign errValid = (state == S_REPORT) && !resOk;
  assign errCode  = errValid ? errReg : ERR_NONE;

  assert_start_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_release_after_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progReq) |-> ($past(initIn) || errValid));

  assert_crc_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errCode == 2'd2) |-> $past(initIn && !doneIn));

  assert_ok_needs_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |-> $past(doneIn));

  assert_result_then_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneOk || errValid) |=> !busy);

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int TIMEOUT_CYC = 1000000,
  parameter int LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] totalBytes,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             progReq,
  input  logic             initIn,
  input  logic             doneIn,
  output logic             cfgClk,
  output logic             cfgDin,
  output logic             busy,
  output logic             doneOk,
  output logic             errValid,
  output logic [1:0]       errCode
);
  dpCtrl_t ctl;
  dpStat_t stat;

  cfgld_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .initIn   (initIn),
    .doneIn   (doneIn),
    .inValid  (inValid),
    .stat     (stat),
    .ctl      (ctl),
    .progReq  (progReq),
    .busy     (busy),
    .inReady  (inReady),
    .doneOk   (doneOk),
    .errValid (errValid),
    .errCode  (errCode)
  );

  cfgld_datapath #(
    .HALF_PERIOD (HALF_PERIOD),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .LEN_W       (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .inData     (inData),
    .totalBytes (totalBytes),
    .stat       (stat),
    .cfgClk     (cfgClk),
    .cfgDin     (cfgDin)
  );

  assert_no_clk_handshake_R3: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> !cfgClk);

  assert_ready_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (busy && !cfgClk));

endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int TB_HALF = 2;
  localparam int TB_TO   = 200;
  localparam int LEN_W   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] totalBytes = '0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady, progReq, cfgClk, cfgDin, busy, doneOk, errValid;
  logic [1:0] errCode;
  logic initIn = 1'b0;
  logic doneIn = 1'b0;

  always #5 clk = ~clk;

  serial_cfg_loader #(.HALF_PERIOD(TB_HALF), .TIMEOUT_CYC(TB_TO), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .totalBytes(totalBytes),
    .inData(inData), .inValid(inValid), .inReady(inReady), .progReq(progReq),
    .initIn(initIn), .doneIn(doneIn), .cfgClk(cfgClk), .cfgDin(cfgDin),
    .busy(busy), .doneOk(doneOk), .errValid(errValid), .errCode(errCode)
  );

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  // source and target model state
  logic [7:0] mem [0:7];
  logic [7:0] rx [0:7];
  int nBytes, idx, initRiseDly, initFallDly, doneAfter, crcAfter;
  int phase, cnt, bitCount, rxCount, hsRises, tailRises, tailBad;
  int progRises, progEarly, resOk, resErr, codeLeak, cyc, resCyc;
  int highRun, minHigh, maxHigh;
  bit seenProg, prevClk, prevProg, fire;
  logic [7:0] shiftIn;
  logic [1:0] resCode;

  always @(negedge clk) begin
    cyc++;
    if (fire) idx++;
    inValid = (idx < nBytes);
    inData  = mem[idx < 8 ? idx : 0];
    fire = inValid && inReady;

    if (progReq && !prevProg) progRises++;
    prevProg = progReq;
    if (progReq && !seenProg) begin seenProg = 1; cnt = 0; end
    if (seenProg && phase == 0) begin
      if (initRiseDly >= 0) begin
        cnt++;
        if (cnt >= initRiseDly) begin initIn = 1; phase = 1; cnt = 0; end
      end
      if (!progReq && !initIn) progEarly++;
    end else if (phase == 1 && !progReq) begin
      if (initFallDly >= 0) begin
        cnt++;
        if (cnt >= initFallDly) begin initIn = 0; phase = 2; end
      end
    end

    if (cfgClk && !prevClk) begin
      if (phase < 2) hsRises++;
      else if (bitCount < 8 * nBytes) begin
        shiftIn = {shiftIn[6:0], cfgDin};
        bitCount++;
        if (bitCount % 8 == 0) begin
          rx[rxCount] = shiftIn;
          rxCount++;
          if (rxCount == crcAfter) initIn = 1;
        end
      end else begin
        tailRises++;
        if (!cfgDin) tailBad++;
      end
    end
    prevClk = cfgClk;

    if (cfgClk) highRun++;
    else if (highRun > 0) begin
      if (tailRises == 0) begin
        if (highRun < minHigh) minHigh = highRun;
        if (highRun > maxHigh) maxHigh = highRun;
      end
      highRun = 0;
    end

    if (phase == 2 && bitCount == 8 * nBytes && doneAfter >= 0 && tailRises >= doneAfter)
      doneIn = 1;
    if (doneOk) resOk++;
    if (errValid) begin resErr++; resCode = errCode; resCyc = cyc; end
    if (!errValid && errCode != 2'd0) codeLeak++;
  end

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setupModel(int n, int rDly, int fDly, int dAfter, int cAfter);
    @(negedge clk); #1;
    nBytes = n; totalBytes = LEN_W'(n);
    idx = 0; fire = 0; initRiseDly = rDly; initFallDly = fDly;
    doneAfter = dAfter; crcAfter = cAfter;
    phase = 0; cnt = 0; bitCount = 0; rxCount = 0; hsRises = 0;
    tailRises = 0; tailBad = 0; progRises = 0; progEarly = 0;
    resOk = 0; resErr = 0; resCode = 0; resCyc = 0;
    highRun = 0; minHigh = 1000; maxHigh = 0;
    seenProg = 0; initIn = 0; doneIn = 0;
    inValid = (n > 0); inData = mem[0];
  endtask

  task automatic pulseStart(output int startCyc);
    @(negedge clk); #1;
    start = 1; startCyc = cyc;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic waitResult(int limit);
    for (int i = 0; i < limit && (resOk + resErr) == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkIdle(string req);
    #2;
    check(req, "busy idle", busy, 0);
    check(req, "progReq idle", progReq, 0);
    check(req, "cfgClk idle", cfgClk, 0);
    check(req, "inReady idle", inReady, 0);
    check(req, "cfgDin idle", cfgDin, 1);
    check(req, "doneOk idle", doneOk, 0);
    check(req, "errValid idle", errValid, 0);
  endtask

  task automatic t_reset;
    checkIdle("R8");
  endtask

  task automatic t_normal;
    int sc;
    mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'hFF; mem[3] = 8'h00; mem[4] = 8'h81;
    setupModel(5, 4, 6, 3, -1);
    pulseStart(sc);
    repeat (40) @(negedge clk);
    #1 start = 1;          // R1: start while busy is ignored
    @(negedge clk); #1 start = 0;
    waitResult(3000);
    check("R8", "success pulses", resOk, 1);
    check("R8", "error pulses", resErr, 0);
    check("R1", "program request raised once", progRises, 1);
    check("R2", "early release", progEarly, 0);
    check("R3", "edges during handshake", hsRises, 0);
    check("R10", "bytes accepted", idx, 5);
    check("R4", "bytes received", rxCount, 5);
    for (int i = 0; i < 5; i++) check("R4", $sformatf("byte %0d", i), rx[i], mem[i]);
    check("R4", "min high half", minHigh, TB_HALF);
    check("R4", "max high half", maxHigh, TB_HALF);
    check("R6", "trailing edges", tailRises, 3);
    check("R6", "trailing data low", tailBad, 0);
    check("R8", "code leak", codeLeak, 0);
    checkIdle("R8");
  endtask

  task automatic t_zero;
    int sc;
    setupModel(0, 2, 2, 0, -1);
    pulseStart(sc);
    waitResult(2000);
    check("R6", "zero-length success", resOk, 1);
    check("R6", "zero-length trailing edges", tailRises, 0);
    check("R10", "zero-length accepted", idx, 0);
    checkIdle("R8");
  endtask

  task automatic t_initRiseTimeout;
    int sc;
    setupModel(2, -1, 2, 1, -1);
    pulseStart(sc);
    waitResult(2000);
    check("R2", "rise timeout pulses", resErr, 1);
    check("R2", "rise timeout code", resCode, 1);
    check("R9", "rise timeout window", (resCyc - sc >= TB_TO && resCyc - sc <= TB_TO + 3), 1);
    check("R2", "no edges", hsRises, 0);
    checkIdle("R8");
  endtask

  task automatic t_initClearTimeout;
    int sc;
    setupModel(2, 3, -1, 1, -1);
    pulseStart(sc);
    waitResult(2000);
    check("R3", "clear timeout pulses", resErr, 1);
    check("R3", "clear timeout code", resCode, 1);
    check("R9", "clear timeout window", (resCyc - sc >= TB_TO + 3 && resCyc - sc <= TB_TO + 12), 1);
    check("R3", "no bytes accepted", idx, 0);
    check("R3", "no edges", hsRises, 0);
    checkIdle("R8");
  endtask

  task automatic t_crc;
    int sc;
    mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'h56; mem[3] = 8'h78;
    setupModel(4, 2, 2, 1, 2);
    pulseStart(sc);
    waitResult(3000);
    check("R5", "crc pulses", resErr, 1);
    check("R5", "crc code", resCode, 2);
    check("R5", "bytes accepted before abort", idx, 2);
    check("R5", "bytes received before abort", rxCount, 2);
    check("R5", "no success", resOk, 0);
    checkIdle("R8");
  endtask

  task automatic t_doneTimeout;
    int sc;
    mem[0] = 8'hC3; mem[1] = 8'h5A;
    setupModel(2, 2, 2, -1, -1);
    pulseStart(sc);
    waitResult(3000);
    check("R7", "done timeout pulses", resErr, 1);
    check("R7", "done timeout code", resCode, 3);
    check("R7", "trailing edges present", (tailRises > 0), 1);
    check("R7", "trailing data low", tailBad, 0);
    check("R4", "byte 0", rx[0], 8'hC3);
    check("R4", "byte 1", rx[1], 8'h5A);
    check("R8", "code leak", codeLeak, 0);
    checkIdle("R8");
  endtask

  initial begin
    cyc = 0; codeLeak = 0; prevClk = 0; prevProg = 0; fire = 0;
    nBytes = 0; idx = 0; phase = 3; seenProg = 1; doneAfter = -1; crcAfter = -1;
    for (int i = 0; i < 8; i++) begin mem[i] = 8'h00; rx[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_zero();
    t_initRiseTimeout();
    t_initClearTimeout();
    t_crc();
    t_doneTimeout();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule